// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division one bit per clock and places the results in two dedicated 32-bit registers, HI and LO, not in a general register file. A multiply splits its 64-bit product: the upper half goes to HI and the lower half to LO. A divide puts the remainder in HI and the quotient in LO. A two-bit operation code selects signed or unsigned operation for each kind. Both register values are always visible on two read ports, one for HI and one for LO, so an instruction that moves from HI or from LO can read them at any time.

A one-cycle start pulse, taken while the unit is idle, captures the operation and both operands. The unit first converts signed operands to magnitudes. It then runs 32 shift-add or restoring-subtract iterations and applies the sign correction as it commits the result. `busy_o` is high for the whole operation. `done_o` pulses in the cycle the new HI/LO values appear. While idle, the unit also accepts direct writes into HI or LO, which serve instructions that move a value into HI or LO.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO read zero and both busy_o and done_o are low.
- R2: With op_i = 2'b01 (unsigned multiply), the unit leaves {HI,LO} equal to the 64-bit unsigned product opa_i × opb_i.
- R3: With op_i = 2'b00 (signed multiply), the unit leaves {HI,LO} equal to the 64-bit two's-complement product of the signed operands.
- R4: With op_i = 2'b11 (unsigned divide), the unit leaves LO = opa_i / opb_i and HI = opa_i mod opb_i.
- R5: With op_i = 2'b10 (signed divide), the quotient in LO is truncated toward zero and the remainder in HI carries the sign of the dividend. 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: A divide with opb_i = 0, signed or unsigned, finishes with the normal timing and leaves LO = 0xFFFFFFFF and HI = opa_i.
- R7: When start_i is sampled at a clock edge while the unit is idle, busy_o is high for the next 33 cycles. Results appear after the 33rd edge following the sampling edge. done_o is high for exactly that one cycle, and busy_o is low in it.
- R8: A start_i pulse while busy_o is high is ignored. The running operation completes with its own operands and op code.
- R9: While busy_o is high, hi_o and lo_o keep the values they had before the operation started.
- R10: While idle, wr_hi_i or wr_lo_i loads wr_data_i into HI or LO at the next edge. While busy, these writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| wr_hi_i | input | 1 | Direct write into HI |
| wr_lo_i | input | 1 | Direct write into LO |
| wr_data_i | input | 32 | Data for direct writes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when HI/LO take a result |
| hi_o | output | 32 | Move-from-HI read port |
| lo_o | output | 32 | Move-from-LO read port |

## Verification
The bench targets the signed extremes. These are 0x80000000 times itself, −1 times −1, and the single overflowing quotient 0x80000000 / −1. A sign-correction error would show up in them as a wrong high word or a flipped sign. Dividing mixed-sign operands such as −7/2 and 7/−2 checks that the remainder follows the dividend and not the divisor. Divide by zero with a negative dividend catches a design that hangs, or one that negates the all-ones quotient to 1. A start, HI/LO writes and reads issued in the middle of an operation would expose a unit that restarts, lets writes through, or shows partial results while busy.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } hilo_op_e;

  // Post-processing control captured at operation start
  typedef struct packed {
    logic is_div;
    logic sign_a;
    logic sign_b;
    logic div_zero;
  } fix_ctl_t;

endpackage

// File: rtl/hilo_operand_prep.sv
module hilo_operand_prep
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output fix_ctl_t     ctl_o
);

  logic is_signed;

  always_comb begin
    is_signed       = (op_i == OP_MUL_S) || (op_i == OP_DIV_S);
    ctl_o.is_div    = op_i[1];
    ctl_o.sign_a    = is_signed & opa_i[W-1];
    ctl_o.sign_b    = is_signed & opb_i[W-1];
    ctl_o.div_zero  = (opb_i == '0);
    mag_a_o         = ctl_o.sign_a ? (-opa_i) : opa_i;
    mag_b_o         = ctl_o.sign_b ? (-opb_i) : opb_i;
  end

endmodule

// File: rtl/hilo_iter_core.sv
module hilo_iter_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           is_div_i,
  input  logic [W-1:0]   mag_a_i,
  input  logic [W-1:0]   mag_b_i,
  output logic           active_o,
  output logic           fin_o,
  output logic [2*W-1:0] work_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2*W-1:0]   work_q, work_d;
  logic [W-1:0]     opb_q, opb_d;
  logic             div_q, div_d;
  logic             en;

  // Step datapaths
  logic [W:0]     mul_sum;
  logic [2*W-1:0] mul_next;
  logic [W:0]     div_shift;
  logic           div_ge;
  logic [W:0]     div_rem;
  logic [2*W-1:0] div_next;

  always_comb begin
    mul_sum  = {1'b0, work_q[2*W-1:W]} + (work_q[0] ? {1'b0, opb_q} : '0);
    mul_next = {mul_sum, work_q[W-1:1]};

    div_shift = {work_q[2*W-1:W], work_q[W-1]};
    div_ge    = (div_shift >= {1'b0, opb_q});
    div_rem   = div_ge ? (div_shift - {1'b0, opb_q}) : div_shift;
    div_next  = {div_rem[W-1:0], work_q[W-2:0], div_ge};
  end

  assign fin_o    = active_q && (cnt_q == '0);
  assign active_o = active_q;
  assign work_o   = work_q;
  assign en       = load_i | active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    work_d   = work_q;
    opb_d    = opb_q;
    div_d    = div_q;
    if (load_i) begin
      active_d = 1'b1;
      cnt_d    = CNT_W'(W);
      work_d   = {{W{1'b0}}, mag_a_i};
      opb_d    = mag_b_i;
      div_d    = is_div_i;
    end else if (fin_o) begin
      active_d = 1'b0;
    end else if (active_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
      work_d = div_q ? div_next : mul_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      work_q   <= '0;
      opb_q    <= '0;
      div_q    <= 1'b0;
    end else if (en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      work_q   <= work_d;
      opb_q    <= opb_d;
      div_q    <= div_d;
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= CNT_W'(W)));

  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_q);

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |=> (active_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/hilo_result_fix.sv
module hilo_result_fix
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] work_i,
  input  fix_ctl_t       ctl_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o
);

  logic [2*W-1:0] prod;
  logic [W-1:0]   quo;
  logic [W-1:0]   rem;

  always_comb begin
    prod = (ctl_i.sign_a ^ ctl_i.sign_b) ? (-work_i) : work_i;
    quo  = (ctl_i.sign_a ^ ctl_i.sign_b) ? (-work_i[W-1:0]) : work_i[W-1:0];
    rem  = ctl_i.sign_a ? (-work_i[2*W-1:W]) : work_i[2*W-1:W];
    if (ctl_i.is_div) begin
      hi_o = rem;
      lo_o = ctl_i.div_zero ? '1 : quo;
    end else begin
      hi_o = prod[2*W-1:W];
      lo_o = prod[W-1:0];
    end
  end

endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         wr_hi_i,
  input  logic         wr_lo_i,
  input  logic [W-1:0] wr_data_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [W-1:0]   mag_a, mag_b;
  fix_ctl_t       ctl_new, ctl_q, ctl_d;
  logic           core_active, core_fin;
  logic [2*W-1:0] work;
  logic [W-1:0]   fix_hi, fix_lo;
  logic           accept;
  logic [W-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic           done_q, done_d;

  hilo_operand_prep #(.W(W)) u_prep (
    .op_i    (op_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .ctl_o   (ctl_new)
  );

  hilo_iter_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .is_div_i (ctl_new.is_div),
    .mag_a_i  (mag_a),
    .mag_b_i  (mag_b),
    .active_o (core_active),
    .fin_o    (core_fin),
    .work_o   (work)
  );

  hilo_result_fix #(.W(W)) u_fix (
    .work_i (work),
    .ctl_i  (ctl_q),
    .hi_o   (fix_hi),
    .lo_o   (fix_lo)
  );

  assign accept = start_i & ~core_active;

  always_comb begin
    ctl_d  = accept ? ctl_new : ctl_q;
    done_d = core_fin;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (core_fin) begin
      hi_d = fix_hi;
      lo_d = fix_lo;
    end else if (!core_active) begin
      if (wr_hi_i) hi_d = wr_data_i;
      if (wr_lo_i) lo_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      done_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (accept) ctl_q <= ctl_d;
      done_q <= done_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign busy_o = core_active;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  p_hold_while_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_active && !core_fin) |=> ($stable(hi_q) && $stable(lo_q)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o);

  p_start_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> $stable(ctl_q));

  p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_fin && ctl_q.is_div && ctl_q.div_zero) |=> (lo_q == '1));

endmodule

// File: tb/hilo_muldiv_bench.sv
`timescale 1ns/1ps
module hilo_muldiv_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [31:0] opa_i, opb_i;
  logic        wr_hi_i, wr_lo_i;
  logic [31:0] wr_data_i;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  hilo_muldiv u_hilo_muldiv (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .wr_data_i(wr_data_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_fn(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = $signed(a);
    sb = $signed(b);
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (op)
      2'b00: ref_fn = sa * sb;
      2'b01: ref_fn = ua * ub;
      2'b10: begin
        if (b == 0) ref_fn = {a, 32'hFFFF_FFFF};
        else begin
          q = sa / sb;
          r = sa % sb;
          ref_fn = {r[31:0], q[31:0]};
        end
      end
      default: begin
        if (b == 0) ref_fn = {a, 32'hFFFF_FFFF};
        else ref_fn = {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00: req_of = "R3";
      2'b01: req_of = "R2";
      2'b10: req_of = "R5";
      default: req_of = "R4";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge after the result is checked.
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit probe, input string req);
    logic [63:0] exp;
    logic [31:0] old_hi, old_lo;
    int n;
    exp    = ref_fn(op, a, b);
    old_hi = hi_o;
    old_lo = lo_o;
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    chk(busy_o == 1'b1, "R7 busy after start", {63'd0, busy_o}, 64'd1);
    while (!done_o && n < 100) begin
      if (probe && n == 4) begin
        // R8 and R10: start and writes while busy
        start_i = 1'b1; op_i = ~op; opa_i = ~a; opb_i = b + 32'd3;
        wr_hi_i = 1'b1; wr_lo_i = 1'b1; wr_data_i = 32'h5A5A_A5A5;
      end else begin
        start_i = 1'b0; wr_hi_i = 1'b0; wr_lo_i = 1'b0;
      end
      if (probe) begin
        chk(hi_o == old_hi && lo_o == old_lo, "R9 HI/LO held while busy",
            {hi_o, lo_o}, {old_hi, old_lo});
        chk(busy_o == 1'b1, "R8 still busy", {63'd0, busy_o}, 64'd1);
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0; wr_hi_i = 1'b0; wr_lo_i = 1'b0;
    chk(n == 34, "R7 latency", 64'(n), 64'd34);
    chk(busy_o == 1'b0, "R7 busy low with done", {63'd0, busy_o}, 64'd0);
    chk({hi_o, lo_o} == exp, req, {hi_o, lo_o}, exp);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; opa_i = '0; opb_i = '0;
    wr_hi_i = 1'b0; wr_lo_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hi_o, lo_o} == 64'd0 && !busy_o && !done_o, "R1 reset state",
        {hi_o, lo_o}, 64'd0);

    // R10: direct writes while idle
    wr_hi_i = 1'b1; wr_data_i = 32'hCAFE_0001;
    @(negedge clk);
    wr_hi_i = 1'b0; wr_lo_i = 1'b1; wr_data_i = 32'h0BAD_F00D;
    @(negedge clk);
    wr_lo_i = 1'b0;
    chk({hi_o, lo_o} == {32'hCAFE_0001, 32'h0BAD_F00D}, "R10 idle writes",
        {hi_o, lo_o}, {32'hCAFE_0001, 32'h0BAD_F00D});

    // Directed corners
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 max unsigned product");
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 -1 * -1");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0, "R3 min * min");
    run_op(2'b00, 32'hFFFF_FFFD, 32'd7, 1'b0, "R3 -3 * 7");
    run_op(2'b11, 32'd100, 32'd7, 1'b0, "R4 100 / 7");
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0, "R5 -7 / 2");
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0, "R5 7 / -2");
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R5 min / -1");
    run_op(2'b11, 32'h1234_5678, 32'd0, 1'b0, "R6 unsigned divide by zero");
    run_op(2'b10, 32'hFFFF_FF00, 32'd0, 1'b0, "R6 signed divide by zero");

    // R8, R9, R10: interference during a running multiply, result must be the original
    run_op(2'b01, 32'h0001_0003, 32'h0002_0005, 1'b1, "R8 start ignored while busy");
    run_op(2'b10, 32'hF000_0001, 32'd13, 1'b1, "R10 writes ignored while busy");

    // Constrained random: all op codes, occasional small divisors
    for (int i = 0; i < 120; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b;
      op = 2'($urandom_range(0, 3));
      a  = $urandom;
      b  = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 15)) : $urandom;
      run_op(op, a, b, 1'b0, req_of(op));
    end

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule